// File: doc/BRIEF.md
# Table Latch Program-Memory Writer

This block carries out the table-write instruction of a small microcontroller core. The core presents a decoded 16-bit instruction word on a start strobe. The block shows the instruction's register address on `opnd_addr`, and the core returns that register's byte on `reg_data` in the same cycle. The block first loads that byte into one half of a 16-bit table latch. It then writes the whole latch to the program-memory word that the 16-bit table pointer selects, and it can step the pointer forward afterwards. No status flags exist and none are touched.

Two memory paths exist, and the pointer value picks one of them. Addresses at or above the `INT_BOUND` parameter are external. An external write takes the acceptance cycle plus one write cycle, which makes two instruction cycles in all. Addresses below the boundary are internal. An internal write holds a programming strobe for `PROG_CYCLES` cycles, and an interrupt request ends it early. While the instruction runs, `busy` tells the core to stall. The core can load the pointer through a small write port while the block is idle.

Top module: `table_word_writer`

## Requirements
- R1: The block accepts a start only when `busy` is low and `instr[15:10]` is 101011. It then shows `busy` high from the next cycle. A start carrying any other opcode leaves `busy` low and leaves the latch unchanged. `opnd_addr` always equals `instr[7:0]`.
- R2: On acceptance, if `instr[9]` is 1 then `reg_data` goes into latch bits 15:8. If `instr[9]` is 0 it goes into bits 7:0. The other byte keeps its value.
- R3: During the completion cycle (`done` high), `mem_wdata` carries the full 16-bit latch including the byte just loaded, and `mem_addr` carries the table pointer.
- R4: When the pointer is at or above `INT_BOUND`, `busy` is high for exactly one cycle. In that cycle `mem_we_ext` and `done` are both high and `mem_prog_int` is low.
- R5: When the pointer is below `INT_BOUND` and no interrupt arrives, `mem_prog_int` and `busy` stay high for exactly `PROG_CYCLES` cycles, and `done` is high only in the last of them.
- R6: An `irq` high during an internal write ends it in that same cycle. `done` and `aborted` are both high in that cycle, and `busy` is low in the next.
- R7: When `instr[8]` is 1, the pointer advances by one at the end of the `done` cycle and wraps from 0xFFFF to 0x0000. When `instr[8]` is 0, it keeps its value.
- R8: A start presented while `busy` is high is ignored. The latch does not change and no extra `done` follows.
- R9: `ptr_ld` loads `ptr_din` into the pointer when `busy` is low and is ignored while `busy` is high.
- R10: A synchronous `rst` clears the latch and the pointer to zero and returns the block to idle, with `busy` low, even in the middle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Instruction start strobe |
| instr | input | 16 | Instruction word |
| opnd_addr | output | 8 | Register address for the operand read |
| reg_data | input | 8 | Register operand byte |
| irq | input | 1 | Interrupt request; ends an internal write |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_din | input | 16 | Pointer load value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final cycle of the write |
| aborted | output | 1 | Internal write ended by interrupt |
| mem_we_ext | output | 1 | External memory write strobe |
| mem_prog_int | output | 1 | Internal programming strobe |
| mem_addr | output | 16 | Program memory address |
| mem_wdata | output | 16 | Program memory data |
| latch_q | output | 16 | Table latch contents |
| ptr_q | output | 16 | Table pointer contents |

## Verification
The write is exercised with both settings of the byte-select flag, so the bench can tell a high-byte load from a low-byte load by the untouched half. It is also exercised with both settings of the increment flag, which separates a stepped pointer from a held one. Pointers on each side of the internal boundary and the all-ones pointer show whether the right path is chosen and whether the increment wraps. Internal writes run to full length, and are also cut by an interrupt in the first and in a middle cycle. Both cases are checked for the exact busy length. Starts and pointer loads offered mid-write, a foreign opcode, and a reset mid-write show that the block refuses stray inputs.

// File: rtl/table_word_writer.sv
module table_word_writer #(
  parameter logic [15:0] INT_BOUND   = 16'h0800,
  parameter int unsigned PROG_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [15:0] instr,
  output logic [7:0]  opnd_addr,
  input  logic [7:0]  reg_data,
  input  logic        irq,
  input  logic        ptr_ld,
  input  logic [15:0] ptr_din,
  output logic        busy,
  output logic        done,
  output logic        aborted,
  output logic        mem_we_ext,
  output logic        mem_prog_int,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  output logic [15:0] latch_q,
  output logic [15:0] ptr_q
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_EXT, S_INT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic             inc_q;
  logic             accept;
  logic             is_int;

  assign opnd_addr    = instr[7:0];
  assign busy         = (state != S_IDLE);
  assign accept       = start && !busy && (instr[15:10] == 6'b101011);
  assign is_int       = (ptr_q < INT_BOUND);
  assign mem_we_ext   = (state == S_EXT);
  assign mem_prog_int = (state == S_INT);
  assign done         = mem_we_ext || (mem_prog_int && (irq || cnt == '0));
  assign aborted      = mem_prog_int && irq;
  assign mem_addr     = ptr_q;
  assign mem_wdata    = latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      inc_q   <= 1'b0;
      latch_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (accept) begin
        if (instr[9]) latch_q[15:8] <= reg_data;
        else          latch_q[7:0]  <= reg_data;
        inc_q <= instr[8];
        cnt   <= CNT_LAST;
        state <= is_int ? S_INT : S_EXT;
      end else if (done) begin
        state <= S_IDLE;
        if (inc_q) ptr_q <= ptr_q + 16'd1;
      end else if (mem_prog_int) begin
        cnt <= cnt - 1'b1;
      end
      if (ptr_ld && !busy) ptr_q <= ptr_din;
    end
  end

  a_r4_ext_write_done: assert property (@(posedge clk) disable iff (rst)
    mem_we_ext |-> (done && !mem_prog_int));
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  a_r6_abort_in_int: assert property (@(posedge clk) disable iff (rst)
    aborted |-> (done && mem_prog_int));
  a_r7_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (done && inc_q) |=> (ptr_q == $past(ptr_q) + 16'd1));
  a_r7_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !inc_q) |=> $stable(ptr_q));
  a_r8_latch_held_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(latch_q));
  a_r9_ptr_ld_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(ptr_q));
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we_ext, mem_prog_int}));
endmodule

// File: tb/tb_table_word_writer.sv
module tb_table_word_writer;
  localparam int PC = 6;

  logic clk = 0, rst = 1, start = 0, irq = 0, ptr_ld = 0;
  logic [15:0] instr = 0, ptr_din = 0;
  logic [7:0]  reg_data = 0, opnd_addr;
  logic busy, done, aborted, mem_we_ext, mem_prog_int;
  logic [15:0] mem_addr, mem_wdata, latch_q, ptr_q;

  table_word_writer #(.INT_BOUND(16'h0800), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .opnd_addr(opnd_addr),
    .reg_data(reg_data), .irq(irq), .ptr_ld(ptr_ld), .ptr_din(ptr_din),
    .busy(busy), .done(done), .aborted(aborted), .mem_we_ext(mem_we_ext),
    .mem_prog_int(mem_prog_int), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .latch_q(latch_q), .ptr_q(ptr_q));

  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] data;
    logic        ext;
    logic        abrt;
    logic [15:0] cycles;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, bcnt = 0;
  logic [15:0] m_latch = 0, m_ptr = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (rst) bcnt = 0;
    else begin
      if (busy) bcnt++;
      if (done) begin
        if (q.size() == 0) chk(0, "R8 done with nothing pending", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(mem_addr == e.addr, "R3 mem_addr", mem_addr, e.addr);
          chk(mem_wdata == e.data, "R3 mem_wdata", mem_wdata, e.data);
          chk(mem_we_ext == e.ext, "R4 external strobe", mem_we_ext, e.ext);
          chk(mem_prog_int == !e.ext, "R5 internal strobe", mem_prog_int, !e.ext);
          chk(aborted == e.abrt, "R6 aborted flag", aborted, e.abrt);
          chk(bcnt == e.cycles, "R5 busy length", bcnt, e.cycles);
        end
        bcnt = 0;
      end
    end
  end

  task automatic setptr(input logic [15:0] v);
    @(negedge clk); ptr_ld = 1; ptr_din = v;
    @(negedge clk); ptr_ld = 0;
    m_ptr = v;
    chk(ptr_q == v, "R9 pointer load", ptr_q, v);
  endtask

  task automatic issue(input bit t, input bit i, input logic [7:0] d,
                       input int abort_at, input bit dup_start, input bit dup_ptr);
    exp_t e;
    bit intl;
    if (t) m_latch[15:8] = d; else m_latch[7:0] = d;
    intl = m_ptr < 16'h0800;
    e.addr = m_ptr; e.data = m_latch; e.ext = !intl;
    e.abrt = intl && abort_at > 0;
    e.cycles = !intl ? 16'd1 : (abort_at > 0 ? 16'(abort_at) : 16'(PC));
    q.push_back(e);
    @(negedge clk); start = 1; instr = {6'b101011, t, i, 8'h21}; reg_data = d;
    chk(opnd_addr == 8'h21, "R1 operand address", opnd_addr, 8'h21);
    @(negedge clk); start = 0; instr = 0;
    chk(busy == 1, "R1 busy after accept", busy, 1);
    if (dup_start || dup_ptr) begin
      if (dup_start) begin start = 1; instr = {6'b101011, 2'b01, 8'h03}; reg_data = 8'hFF; end
      if (dup_ptr) begin ptr_ld = 1; ptr_din = 16'h9999; end
      @(negedge clk); start = 0; ptr_ld = 0; instr = 0;
    end
    if (abort_at > 0) begin
      repeat (abort_at - 1) @(negedge clk);
      irq = 1;
      @(negedge clk); irq = 0;
    end
    while (busy) @(negedge clk);
    if (i) m_ptr = m_ptr + 16'd1;
    chk(latch_q == m_latch, "R2 latch after write", latch_q, m_latch);
    chk(ptr_q == m_ptr, "R7 pointer after write", ptr_q, m_ptr);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R10 reset busy", busy, 0);
    chk(latch_q == 0, "R10 reset latch", latch_q, 0);
    chk(ptr_q == 0, "R10 reset pointer", ptr_q, 0);

    setptr(16'h1234);
    issue(1, 1, 8'hAA, 0, 0, 0);
    issue(0, 0, 8'h55, 0, 0, 0);

    @(negedge clk); start = 1; instr = 16'hA1F0; reg_data = 8'h77;
    @(negedge clk); start = 0; instr = 0;
    chk(busy == 0, "R1 foreign opcode no busy", busy, 0);
    chk(latch_q == m_latch, "R1 foreign opcode latch", latch_q, m_latch);

    setptr(16'h0100);
    issue(0, 1, 8'h34, 0, 0, 0);
    issue(1, 1, 8'h12, 3, 0, 0);
    issue(0, 0, 8'h9C, 1, 0, 0);
    issue(1, 0, 8'h6E, 0, 1, 0);
    issue(0, 1, 8'h41, 0, 0, 1);
    setptr(16'h07FF);
    issue(1, 1, 8'hC3, 0, 0, 0);
    issue(0, 0, 8'h5A, 0, 0, 0);

    setptr(16'hFFFF);
    issue(0, 1, 8'hE7, 0, 0, 0);
    chk(ptr_q == 16'h0000, "R7 pointer wrap", ptr_q, 16'h0000);

    setptr(16'h0010);
    @(negedge clk); start = 1; instr = {6'b101011, 2'b11, 8'h05}; reg_data = 8'h81;
    @(negedge clk); start = 0; instr = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_latch = 0; m_ptr = 0;
    chk(busy == 0, "R10 mid-write reset busy", busy, 0);
    chk(latch_q == 0, "R10 mid-write reset latch", latch_q, 0);
    chk(ptr_q == 0, "R10 mid-write reset pointer", ptr_q, 0);
    repeat (PC + 2) @(negedge clk);
    chk(q.size() == 0, "R8 no pending writes", q.size(), 0);
    summary();
    $finish;
  end
endmodule